// File: doc/BRIEF.md
# Masked Two-Bit Event Flag Aggregator

This block gathers two-bit event flags from up to 32 sources on an interconnect and turns them into two interrupt request lines for a processor interrupt controller. Each source drives a flag on index 0 and a flag on index 1. Per index there is an enable mask with one bit per source. Output line n is the registered OR of every source's flag n gated by its enable bit. The path runs beside the interconnect data traffic and never stalls it.

Software reaches the block through a small register port. The registers are grouped by flag index, not by source. One mask word and one live status word exist per index, and bit i of each word belongs to source i. Two read-only words give a block type and a version that carries the source count. The flags are level-sensitive and are cleared at their origin, so the status words have no clear action. The two output lines use the same format as one source's flag pair. Two aggregators can therefore feed a third instance as two of its sources and build a merge tree.

Top module: `flagagg_top`

## Requirements
- R1: `irq_o[n]` equals the OR over all sources i of (flag n of source i AND mask bit i of index n), captured by one flop. Flags present before a rising edge are visible on `irq_o` just after that edge.
- R2: After reset both `irq_o` bits are 0, and each mask word holds 1 in bits 0..NUM_SRC-1 and 0 above them.
- R3: A write to byte offset 0x08 loads the mask for index 0 and a write to 0x0C loads the mask for index 1. The new mask first affects `irq_o` at the clock edge after the write edge.
- R4: A read of offset 0x10 returns the live, unmasked index-0 flags of all sources, and 0x14 returns the index-1 flags. Bit i is source i, sampled at the request edge.
- R5: Read data appears on `reg_rdata_o` in the cycle after the read request. After any cycle without a read request, `reg_rdata_o` is 0.
- R6: Offset 0x00 reads the constant 32'h464C_4147. Offset 0x04 reads 32'h0001_00NN, where NN is NUM_SRC.
- R7: Writes to 0x00, 0x04, 0x10, 0x14 and to any unmapped or misaligned offset change no state. Unmapped offsets read 0.
- R8: Mask and status bits at positions NUM_SRC and above read 0, and write data in those positions is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flag0_i | input | NUM_SRC | Index-0 flag of each source, bit i = source i |
| flag1_i | input | NUM_SRC | Index-1 flag of each source, bit i = source i |
| reg_valid_i | input | 1 | Register request valid for one cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | 2 | Aggregated interrupt lines, bit n = flag index n |

## Verification
Every cycle, the assertions check these behaviours. An output line can only be high if some source raised that flag index on the previous edge. The read port is idle after non-read cycles. A status read returns the flags sampled at the request edge. The identification words are constant. A cleared mask silences its line from the second edge onward. The bench scenarios cover behaviour that depends on exact mask and flag patterns. They also cover the reset contents of the masks, the discarding of writes to read-only, unmapped and out-of-range positions, and the exact one-edge delay before a new mask takes effect.

// File: rtl/flagagg_pkg.sv
package flagagg_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_IDX = 2;

    localparam logic [7:0] OFF_CORE_ID = 8'h00;
    localparam logic [7:0] OFF_VERSION = 8'h04;
    localparam logic [7:0] OFF_MASK0   = 8'h08;
    localparam logic [7:0] OFF_MASK1   = 8'h0C;
    localparam logic [7:0] OFF_STAT0   = 8'h10;
    localparam logic [7:0] OFF_STAT1   = 8'h14;

    localparam logic [WORD_W-1:0] CORE_ID_VAL = 32'h464C_4147;
    localparam logic [15:0]       VERSION_HI  = 16'h0001;

    typedef enum logic [2:0] {
        SEL_ID, SEL_VER, SEL_MASK0, SEL_MASK1, SEL_STAT0, SEL_STAT1, SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/flagagg_maskbank.sv
module flagagg_maskbank #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_IDX = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_IDX-1:0]               we_i,
    input  logic [NUM_SRC-1:0]               wdata_i,
    output logic [NUM_IDX-1:0][NUM_SRC-1:0]  mask_o
);
    typedef struct packed {
        logic [NUM_IDX-1:0][NUM_SRC-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int n = 0; n < NUM_IDX; n++) begin
            if (we_i[n]) begin
                state_d.mask[n] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.mask <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;
endmodule

// File: rtl/flagagg_reduce.sv
module flagagg_reduce #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_IDX = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_IDX-1:0][NUM_SRC-1:0]  flags_i,
    input  logic [NUM_IDX-1:0][NUM_SRC-1:0]  mask_i,
    output logic [NUM_IDX-1:0]               irq_o
);
    typedef struct packed {
        logic [NUM_IDX-1:0] irq;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int n = 0; n < NUM_IDX; n++) begin
            state_d.irq[n] = |(flags_i[n] & mask_i[n]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;
endmodule

// File: rtl/flagagg_regport.sv
module flagagg_regport
    import flagagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             valid_i,
    input  logic                             write_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [WORD_W-1:0]                wdata_i,
    input  logic [NUM_IDX-1:0][NUM_SRC-1:0]  mask_i,
    input  logic [NUM_IDX-1:0][NUM_SRC-1:0]  flags_i,
    output logic [NUM_IDX-1:0]               mask_we_o,
    output logic [NUM_SRC-1:0]               mask_wdata_o,
    output logic [WORD_W-1:0]                rdata_o
);
    localparam logic [WORD_W-1:0] VERSION_VAL = {VERSION_HI, 8'h00, 8'(NUM_SRC)};

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t   state_d, state_q;
    reg_sel_e sel;
    logic [WORD_W-1:0] word;

    function automatic logic [WORD_W-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return w;
    endfunction

    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFF_CORE_ID): sel = SEL_ID;
            ADDR_W'(OFF_VERSION): sel = SEL_VER;
            ADDR_W'(OFF_MASK0):   sel = SEL_MASK0;
            ADDR_W'(OFF_MASK1):   sel = SEL_MASK1;
            ADDR_W'(OFF_STAT0):   sel = SEL_STAT0;
            ADDR_W'(OFF_STAT1):   sel = SEL_STAT1;
            default:              sel = SEL_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_ID:    word = CORE_ID_VAL;
            SEL_VER:   word = VERSION_VAL;
            SEL_MASK0: word = widen(mask_i[0]);
            SEL_MASK1: word = widen(mask_i[1]);
            SEL_STAT0: word = widen(flags_i[0]);
            SEL_STAT1: word = widen(flags_i[1]);
            default:   word = '0;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.rdata = (valid_i && !write_i) ? word : '0;
        mask_we_o     = '0;
        mask_we_o[0]  = valid_i && write_i && (sel == SEL_MASK0);
        mask_we_o[1]  = valid_i && write_i && (sel == SEL_MASK1);
        mask_wdata_o  = wdata_i[NUM_SRC-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;
endmodule

// File: rtl/flagagg_top.sv
module flagagg_top
    import flagagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] flag0_i,
    input  logic [NUM_SRC-1:0] flag1_i,
    input  logic               reg_valid_i,
    input  logic               reg_write_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [1:0]         irq_o
);
    logic [NUM_IDX-1:0][NUM_SRC-1:0] flags_w;
    logic [NUM_IDX-1:0][NUM_SRC-1:0] mask_w;
    logic [NUM_IDX-1:0]              mask_we_w;
    logic [NUM_SRC-1:0]              mask_wdata_w;

    assign flags_w[0] = flag0_i;
    assign flags_w[1] = flag1_i;

    flagagg_maskbank #(.NUM_SRC(NUM_SRC), .NUM_IDX(NUM_IDX)) u_maskbank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (mask_we_w),
        .wdata_i (mask_wdata_w),
        .mask_o  (mask_w)
    );

    flagagg_reduce #(.NUM_SRC(NUM_SRC), .NUM_IDX(NUM_IDX)) u_reduce (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flags_i (flags_w),
        .mask_i  (mask_w),
        .irq_o   (irq_o)
    );

    flagagg_regport #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regport (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .valid_i      (reg_valid_i),
        .write_i      (reg_write_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .mask_i       (mask_w),
        .flags_i      (flags_w),
        .mask_we_o    (mask_we_w),
        .mask_wdata_o (mask_wdata_w),
        .rdata_o      (reg_rdata_o)
    );
endmodule

// File: rtl/flagagg_chk.sv
module flagagg_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] flag0_i,
    input logic [NUM_SRC-1:0] flag1_i,
    input logic               reg_valid_i,
    input logic               reg_write_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [31:0]        reg_wdata_i,
    input logic [31:0]        reg_rdata_o,
    input logic [1:0]         irq_o
);
    logic rd_req;
    assign rd_req = reg_valid_i && !reg_write_i;

    AST_IRQ0_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[0] |-> $past(|flag0_i)); // R1
    AST_IRQ1_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[1] |-> $past(|flag1_i)); // R1
    AST_MASK0_CLEAR_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_valid_i && reg_write_i && reg_addr_i == ADDR_W'(8'h08)
         && reg_wdata_i[NUM_SRC-1:0] == '0) |=> ##1 !irq_o[0]); // R3
    AST_STAT0_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && reg_addr_i == ADDR_W'(8'h10)) |=> reg_rdata_o == 32'($past(flag0_i))); // R4
    AST_STAT1_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && reg_addr_i == ADDR_W'(8'h14)) |=> reg_rdata_o == 32'($past(flag1_i))); // R4
    AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req |=> reg_rdata_o == '0); // R5
    AST_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && reg_addr_i == ADDR_W'(8'h00)) |=> reg_rdata_o == 32'h464C_4147); // R6
endmodule

bind flagagg_top flagagg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flag0_i     (flag0_i),
    .flag1_i     (flag1_i),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/test_flagagg_top.sv
module test_flagagg_top;
    localparam int unsigned NS = 8;
    localparam int unsigned AW = 8;
    localparam int unsigned NVEC = 8;
    // fields: flag0, flag1, mask0, mask1, expected {irq1,irq0}
    localparam logic [33:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00},
        {8'h01, 8'h00, 8'hFF, 8'hFF, 2'b01},
        {8'h00, 8'h80, 8'hFF, 8'hFF, 2'b10},
        {8'h0F, 8'hF0, 8'hF0, 8'h0F, 2'b00},
        {8'h0F, 8'hF0, 8'h08, 8'h10, 2'b11},
        {8'hAA, 8'h55, 8'h55, 8'hAA, 2'b00},
        {8'hAA, 8'h55, 8'h02, 8'h00, 2'b01},
        {8'hFF, 8'hFF, 8'h00, 8'h80, 2'b10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] flag0 = '0, flag1 = '0;
    logic          valid = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0, rdata;
    logic [1:0]    irq;
    int            n_run = 0, n_fail = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    flagagg_top #(.NUM_SRC(NS), .ADDR_W(AW)) i_flagagg_top (
        .clk_i(clk), .rst_ni(rst_n), .flag0_i(flag0), .flag1_i(flag1),
        .reg_valid_i(valid), .reg_write_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        valid = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 irq", 32'(irq), 32'h0);
        reg_rd(8'h08, r); check("R2 mask0", r, 32'h0000_00FF);
        reg_rd(8'h0C, r); check("R2 mask1", r, 32'h0000_00FF);
        // R6 identification
        reg_rd(8'h00, r); check("R6 id", r, 32'h464C_4147);
        reg_rd(8'h04, r); check("R6 version", r, 32'h0001_0008);

        // R1 / R3 vector walk
        for (int i = 0; i < NVEC; i++) begin
            reg_wr(8'h08, {24'hABCDEF, VEC[i][17:10]});
            reg_wr(8'h0C, {24'h123456, VEC[i][9:2]});
            flag0 = VEC[i][33:26];
            flag1 = VEC[i][25:18];
            @(negedge clk);
            check($sformatf("R1 vec%0d", i), 32'(irq), 32'(VEC[i][1:0]));
        end

        // R3 mask timing: one edge of old mask, then new mask
        flag0 = 8'h01; flag1 = 8'h00;
        reg_wr(8'h08, 32'h0000_0001);
        @(negedge clk);
        check("R3 before", 32'(irq), 32'h1);
        reg_wr(8'h08, 32'h0);
        check("R3 old mask edge", 32'(irq), 32'h1);
        @(negedge clk);
        check("R3 new mask edge", 32'(irq), 32'h0);

        // R8 upper bits discarded
        reg_wr(8'h08, 32'hFFFF_FF00);
        reg_rd(8'h08, r); check("R8 upper discarded", r, 32'h0);
        reg_wr(8'h08, 32'hFFFF_FF3C);
        reg_rd(8'h08, r); check("R8 low kept", r, 32'h0000_003C);

        // R4 status is unmasked and live
        flag0 = 8'h5A; flag1 = 8'hC3;
        reg_rd(8'h10, r); check("R4 stat0", r, 32'h0000_005A);
        reg_rd(8'h14, r); check("R4 stat1", r, 32'h0000_00C3);

        // R5 idle read data
        @(negedge clk);
        check("R5 idle", rdata, 32'h0);

        // R7 ignored writes
        reg_wr(8'h00, 32'h0);
        reg_wr(8'h04, 32'h0);
        reg_wr(8'h10, 32'h0);
        reg_wr(8'h14, 32'hFFFF_FFFF);
        reg_wr(8'h18, 32'h0);
        reg_wr(8'h09, 32'h0);
        reg_rd(8'h00, r); check("R7 id kept", r, 32'h464C_4147);
        reg_rd(8'h08, r); check("R7 mask0 kept", r, 32'h0000_003C);
        reg_rd(8'h0C, r); check("R7 mask1 kept", r, 32'h0000_0080);
        reg_rd(8'h18, r); check("R7 unmapped read", r, 32'h0);
        reg_rd(8'h10, r); check("R7 stat0 live", r, 32'h0000_005A);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule